// File: doc/BRIEF.md
# Mechanical shutter still-capture sequencer

This block runs one still-capture cycle of a CCD camera fitted with a mechanical shutter. While idle it leaves the sensor in fast monitoring readout, with the substrate bias control low so that bright scenes do not bloom. A capture trigger starts the cycle. The sequencer raises the bias control, waits a fixed lead time counted in millisecond ticks, and then opens the shutter for the programmed number of milliseconds. After the shutter closes it runs a high-speed vertical sweep to flush the blooming charge that built up in the vertical register. It then selects full readout for two consecutive fields and spends one more field in fast mode before it returns to idle.

The frame timing generator supplies single-cycle vertical (`vd_i`) and horizontal (`hd_i`) sync pulses, and a free-running single-cycle `ms_tick_i` marks each millisecond. The bias lead and the exposure are timed in ticks. Every other change of state waits for a vertical sync pulse. The frame-valid flag goes high only during the two full-readout fields, so the downstream pipeline discards every frame that overlaps the exposure or the sweep.

Top module: `shutter_seq`

## Requirements
- R1: While reset is held, and right after it is released, every output is low. Low on `full_mode_o` means fast monitoring readout.
- R2: In idle, a `capture_i` pulse is latched together with the value on `exposure_ms_i`, and `busy_o` rises in the next cycle. The cycle itself begins on the next `vd_i` pulse: at that edge `bias_ctl_o` rises.
- R3: `shutter_open_o` rises on the LEAD_TICKS-th `ms_tick_i` seen after `bias_ctl_o` rose. `bias_ctl_o` stays high until the shutter closes. The default of 21 ticks guarantees at least 20 ms of lead.
- R4: The shutter stays open for exactly as many ticks as the latched exposure value, with 0 treated as 1. It closes on a tick edge, and in that same edge `bias_ctl_o` falls and `sweep_en_o` rises.
- R5: `sweep_en_o` falls only on a `vd_i` pulse, and only once a full field has passed during the sweep (at least two `vd_i` pulses including the ending one) and at least SWEEP_LINES `hd_i` pulses have been counted.
- R6: When the sweep ends, `full_mode_o` and `frame_valid_o` rise together and stay high for exactly two fields bounded by `vd_i`. `field_id_o` is 0 in the first field and 1 in the second.
- R7: After the second field, one restore field follows in fast mode in which only `busy_o` is high. On the next `vd_i` the block returns to idle with `busy_o` low.
- R8: A `capture_i` pulse that arrives while a capture is pending or in progress is ignored. It neither changes the latched exposure nor starts a second cycle.
- R9: Outputs follow the fixed order idle, pending, lead, exposure, sweep, field 0, field 1, restore, idle. `frame_valid_o` is low at every point outside the two readout fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_i | input | 1 | Single-cycle capture request |
| exposure_ms_i | input | EXP_W | Exposure length in ms, latched with the request |
| vd_i | input | 1 | Vertical sync pulse, one cycle per field |
| hd_i | input | 1 | Horizontal sync pulse, one cycle per line |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| shutter_open_o | output | 1 | Mechanical shutter drive, 1 = open |
| bias_ctl_o | output | 1 | Substrate bias control |
| sweep_en_o | output | 1 | High-speed vertical sweep enable |
| full_mode_o | output | 1 | Readout select: 1 full two-field, 0 fast monitoring |
| field_id_o | output | 1 | Field index during full readout |
| frame_valid_o | output | 1 | Output frame is usable |
| busy_o | output | 1 | Capture pending or in progress |

## Verification
The hardest cases are the ones where sweep exit and trigger rejection depend on how events line up in time. Two examples are a sweep that begins partway through a field, and a second trigger that arrives while the first one is still waiting for its vertical sync. The stimulus keeps tick, line and field pulses running at fixed, unrelated phases. It places each trigger at a chosen offset inside a field and sends a second trigger, with a different exposure, both while the first is pending and while the shutter is open. A monitor counts the tick, line and field pulses that each output phase spans and compares the order of output phases with a queue of expected patterns.

// File: rtl/shutseq_pkg.sv
package shutseq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_EXPOSE,
        SQ_SWEEP,
        SQ_FIELD_A,
        SQ_FIELD_B,
        SQ_RESTORE
    } seq_state_e;
endpackage

// File: rtl/event_counter.sv
module event_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && (cnt_q != {W{1'b1}}))
            cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import shutseq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       pend_i,
    output logic       shutter_open_o,
    output logic       bias_ctl_o,
    output logic       sweep_en_o,
    output logic       full_mode_o,
    output logic       field_id_o,
    output logic       frame_valid_o,
    output logic       busy_o
);
    always_comb begin
        shutter_open_o = 1'b0;
        bias_ctl_o     = 1'b0;
        sweep_en_o     = 1'b0;
        full_mode_o    = 1'b0;
        field_id_o     = 1'b0;
        frame_valid_o  = 1'b0;
        busy_o         = pend_i || (state_i != SQ_IDLE);
        case (state_i)
            SQ_LEAD:    bias_ctl_o = 1'b1;
            SQ_EXPOSE: begin
                bias_ctl_o     = 1'b1;
                shutter_open_o = 1'b1;
            end
            SQ_SWEEP:   sweep_en_o = 1'b1;
            SQ_FIELD_A: begin
                full_mode_o   = 1'b1;
                frame_valid_o = 1'b1;
            end
            SQ_FIELD_B: begin
                full_mode_o   = 1'b1;
                frame_valid_o = 1'b1;
                field_id_o    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutseq_pkg::*;
#(
    parameter int EXP_W       = 16,
    parameter int LEAD_TICKS  = 21,
    parameter int SWEEP_LINES = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [EXP_W-1:0] exposure_ms_i,
    input  logic             vd_i,
    input  logic             hd_i,
    input  logic             ms_tick_i,
    output logic             shutter_open_o,
    output logic             bias_ctl_o,
    output logic             sweep_en_o,
    output logic             full_mode_o,
    output logic             field_id_o,
    output logic             frame_valid_o,
    output logic             busy_o
);
    localparam int LEAD_W = $clog2(LEAD_TICKS + 1);
    localparam int MS_W   = (EXP_W > LEAD_W) ? EXP_W : LEAD_W;
    localparam int CMP_W  = MS_W + 1;
    localparam int LN_W   = $clog2(SWEEP_LINES + 1);

    typedef struct packed {
        seq_state_e       state;
        logic             pend;
        logic             vd_seen;
        logic [EXP_W-1:0] exp_ms;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [MS_W-1:0]  ms_cnt;
    logic [LN_W-1:0]  ln_cnt;
    logic             cnt_clr;
    logic [EXP_W-1:0] exp_eff;
    logic [CMP_W-1:0] ms_done_cnt;
    logic             lead_done, exp_done, sweep_ok;

    assign exp_eff     = (r_q.exp_ms == '0) ? {{(EXP_W-1){1'b0}}, 1'b1} : r_q.exp_ms;
    assign ms_done_cnt = {1'b0, ms_cnt} + {{MS_W{1'b0}}, 1'b1};
    assign lead_done   = ms_tick_i && (ms_cnt == MS_W'(LEAD_TICKS - 1));
    assign exp_done    = ms_tick_i && (ms_done_cnt >= CMP_W'(exp_eff));
    assign sweep_ok    = r_q.vd_seen && (ln_cnt >= LN_W'(SWEEP_LINES));

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            SQ_IDLE: begin
                if (capture_i && !r_q.pend) begin
                    r_d.pend   = 1'b1;
                    r_d.exp_ms = exposure_ms_i;
                end
                if (vd_i && (r_q.pend || capture_i)) begin
                    r_d.state = SQ_LEAD;
                    r_d.pend  = 1'b0;
                end
            end
            SQ_LEAD:
                if (lead_done) r_d.state = SQ_EXPOSE;
            SQ_EXPOSE:
                if (exp_done) begin
                    r_d.state   = SQ_SWEEP;
                    r_d.vd_seen = 1'b0;
                end
            SQ_SWEEP:
                if (vd_i) begin
                    if (sweep_ok) r_d.state = SQ_FIELD_A;
                    else          r_d.vd_seen = 1'b1;
                end
            SQ_FIELD_A:
                if (vd_i) r_d.state = SQ_FIELD_B;
            SQ_FIELD_B:
                if (vd_i) r_d.state = SQ_RESTORE;
            SQ_RESTORE:
                if (vd_i) r_d.state = SQ_IDLE;
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= SQ_IDLE;
            r_q.pend    <= 1'b0;
            r_q.vd_seen <= 1'b0;
            r_q.exp_ms  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_clr = (r_d.state != r_q.state);

    event_counter #(.W(MS_W)) u_ms_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(ms_tick_i), .count_o(ms_cnt)
    );

    event_counter #(.W(LN_W)) u_ln_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(hd_i), .count_o(ln_cnt)
    );

    seq_decode u_decode (
        .state_i(r_q.state), .pend_i(r_q.pend),
        .shutter_open_o(shutter_open_o), .bias_ctl_o(bias_ctl_o),
        .sweep_en_o(sweep_en_o), .full_mode_o(full_mode_o),
        .field_id_o(field_id_o), .frame_valid_o(frame_valid_o),
        .busy_o(busy_o)
    );

    assert_bias_starts_on_vd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_ctl_o) |-> $past(vd_i));
    assert_shutter_after_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutter_open_o) |-> ($past(ms_tick_i) && ($past(ms_cnt) == MS_W'(LEAD_TICKS - 1))));
    assert_close_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutter_open_o) |-> ($past(ms_tick_i) && sweep_en_o && !bias_ctl_o));
    assert_sweep_long_enough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweep_en_o) |-> ($past(vd_i) && ($past(ln_cnt) >= LN_W'(SWEEP_LINES))));
    assert_readout_on_vd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_valid_o) || $fell(frame_valid_o) || $rose(field_id_o)) |-> $past(vd_i));
    assert_idle_bias_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bias_ctl_o && !full_mode_o));
    assert_valid_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> (full_mode_o && !shutter_open_o && !sweep_en_o));
endmodule

// File: tb/shutter_seq_tb.sv
module shutter_seq_tb;
    localparam int EXP_W = 8, LEAD = 3, SWL = 12;
    localparam logic [6:0] P_IDLE = 7'b0000000, P_PEND = 7'b1000000, P_LEAD = 7'b1100000,
        P_EXP = 7'b1110000, P_SWP = 7'b1001000, P_F0 = 7'b1000110, P_F1 = 7'b1000111;

    logic clk = 1'b0, rst_n = 1'b0, capture = 1'b0, vd = 1'b0, hd = 1'b0, tick = 1'b0;
    logic [EXP_W-1:0] exp_in = '0;
    logic shut, bias, swp, full, fid, valid, busy;
    int errors = 0, checks = 0, cyc = 0, exp_want = 1;
    bit running = 1'b0, done = 1'b0;
    logic [6:0] expq[$];

    always #10 clk = ~clk;

    shutter_seq #(.EXP_W(EXP_W), .LEAD_TICKS(LEAD), .SWEEP_LINES(SWL)) u_dut (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .exposure_ms_i(exp_in),
        .vd_i(vd), .hd_i(hd), .ms_tick_i(tick), .shutter_open_o(shut), .bias_ctl_o(bias),
        .sweep_en_o(swp), .full_mode_o(full), .field_id_o(fid), .frame_valid_o(valid),
        .busy_o(busy));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #2;
        cyc++;
        tick = (cyc % 10 == 9);
        hd   = (cyc % 5 == 4);
        vd   = (cyc % 50 == 49);
    end

    // monitor: pops expected output patterns and measures phase lengths
    logic [6:0] vprev = '0;
    logic vd_p = 0, hd_p = 0, tk_p = 0;
    int lead_tk = 0, exp_tk = 0, sw_vd = 0, sw_hd = 0, val_vd = 0;
    always @(negedge clk) begin
        logic [6:0] v, e;
        v = {busy, bias, shut, swp, full, valid, fid};
        if (running) begin
            if (vprev[5] && !vprev[4] && tk_p) lead_tk++;
            if (vprev[4] && tk_p) exp_tk++;
            if (vprev[3] && vd_p) sw_vd++;
            if (vprev[3] && hd_p) sw_hd++;
            if (vprev[1] && vd_p) val_vd++;
            if (v != vprev) begin
                if (expq.size() == 0) check(1'b0, "R9 unexpected change", int'(v), int'(vprev));
                else begin
                    e = expq.pop_front();
                    check(v == e, "R9 phase order", int'(v), int'(e));
                end
                if (v == P_LEAD || v == P_F0 || v == P_F1 || (v == P_PEND && vprev == P_F1) || v == P_IDLE)
                    check(vd_p, "R2/R6/R7 change aligned to vd", int'(vd_p), 1);
                if (v[5] && !vprev[5]) begin lead_tk = 0; exp_tk = 0; end
                if (v[4] && !vprev[4]) begin
                    check(lead_tk == LEAD, "R3 lead ticks", lead_tk, LEAD);
                    check(tk_p, "R3 open on tick", int'(tk_p), 1);
                end
                if (!v[4] && vprev[4]) begin
                    check(exp_tk == exp_want, "R4 exposure ticks", exp_tk, exp_want);
                    sw_vd = 0; sw_hd = 0;
                end
                if (!v[3] && vprev[3]) begin
                    check(sw_vd >= 2, "R5 sweep spans a field", sw_vd, 2);
                    check(sw_hd >= SWL, "R5 sweep lines", sw_hd, SWL);
                    val_vd = 0;
                end
                if (!v[1] && vprev[1]) check(val_vd == 2, "R6 two readout fields", val_vd, 2);
            end
        end
        vprev = v; vd_p = vd; hd_p = hd; tk_p = tick;
    end

    task automatic pulse_capture(input logic [EXP_W-1:0] x);
        @(posedge clk); #2; capture = 1'b1; exp_in = x;
        @(posedge clk); #2; capture = 1'b0; exp_in = 8'd77;
    endtask

    // driver: pushes the expected phase sequence, then stimulates one capture
    task automatic run_capture(input logic [EXP_W-1:0] x, input bit dup_pend, input bit dup_exp);
        exp_want = (x == 0) ? 1 : int'(x);
        expq.push_back(P_PEND); expq.push_back(P_LEAD); expq.push_back(P_EXP);
        expq.push_back(P_SWP);  expq.push_back(P_F0);   expq.push_back(P_F1);
        expq.push_back(P_PEND); expq.push_back(P_IDLE);
        while (cyc % 50 != 10) @(posedge clk);
        pulse_capture(x);
        if (dup_pend) begin
            repeat (3) @(posedge clk);
            pulse_capture(8'd9);   // R8: ignored while pending
        end
        if (dup_exp) begin
            while (!shut) @(posedge clk);
            pulse_capture(8'd9);   // R8: ignored while shutter open
        end
        while (busy || expq.size() != 0) @(posedge clk);
        repeat (150) begin
            @(negedge clk);
            if (busy) break;
        end
        check(!busy, "R8 no second cycle", int'(busy), 0);
        check(expq.size() == 0, "R7 returned to idle", expq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, bias, shut, swp, full, valid, fid} == 7'b0, "R1 reset outputs",
              int'({busy, bias, shut, swp, full, valid, fid}), 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        check({busy, bias, shut, swp, full, valid, fid} == 7'b0, "R1 after reset",
              int'({busy, bias, shut, swp, full, valid, fid}), 0);
        running = 1'b1;
        run_capture(8'd5, 1'b0, 1'b0);   // R2 R3 R4 R5 R6 R7
        run_capture(8'd0, 1'b0, 1'b0);   // R4 zero as one
        run_capture(8'd2, 1'b1, 1'b1);   // R8 duplicate triggers
        run_capture(8'd13, 1'b0, 1'b0);  // R5 sweep from other phase
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule